// File: doc/BRIEF.md
# Renamed Floating-Point Word Transfer Merge Unit

This block moves 32-bit words into and out of a 64-bit floating-point register file that sits behind register renaming. Each request names a logical register. A rename map turns that name into a physical register. A word that is written into one half of a register cannot use a partial write enable, because every destination gets a fresh physical register. So the unit reads the old doubleword through the single shared read port, splices the new word into the chosen half, writes all 64 bits to the new physical register, and points the map entry at it. The caller supplies the new physical tag; free-list handling lives elsewhere.

In paired mode, each even/odd pair of logical numbers names one doubleword. The low bit of the logical number is cleared before the map is consulted. That bit then selects the low half (even) or the high half (odd). Odd map entries are left alone and keep their last physical register, which becomes visible again once paired mode is turned off. Doubleword transfers move the whole register and never merge. With paired mode off, logical numbers are used as given. A word write then places the word in the low half and clears the high half.

Top module: `fp_word_merge`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, and every logical register reads as all zeros in either mode.
- R2: In paired mode, a word write (op 2'b00) to an odd logical number replaces bits 63:32 of the pair, and one to an even number replaces bits 31:0. The other half keeps its previous value.
- R3: In paired mode, a logical number and that number with bit 0 cleared share one map entry. A doubleword read of either number returns the same 64-bit value.
- R4: A word write is held for two cycles. `req_ready` is 0 in the cycle after the write is accepted and 1 again in the cycle after that. A request offered while `req_ready` is 0 waits, and once accepted it observes the merged value.
- R5: A word read (op 2'b01) raises `rd_valid` in the cycle after acceptance. It returns the selected half in `rd_data[31:0]` and zeros in `rd_data[63:32]`.
- R6: A doubleword write (op 2'b10) stores all 64 bits of `req_wdata` in one cycle, and `req_ready` stays 1.
- R7: A doubleword read (op 3, 2'b11) raises `rd_valid` in the cycle after acceptance with the full 64-bit value. A write never raises `rd_valid`.
- R8: With paired mode off, the logical number is used unchanged. A word write stores `{32'h0, word}`, and a word read returns the low half.
- R9: Traffic in paired mode never changes the map entry of an odd logical number. After paired mode is turned off, such a register reads the value it held before paired mode began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paired_mode | input | 1 | 1 = even/odd pairs form one doubleword |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 2 | 0 word write, 1 word read, 2 doubleword write, 3 doubleword read |
| req_lreg | input | 5 | Logical register number |
| req_tag | input | 6 | Fresh physical register for writes |
| req_wdata | input | 64 | Write data (word writes use bits 31:0) |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 64 | Read result |

## Verification
The shared read port serves two functions: the merge of a pending word write, and a new read request. Both can want the port in the same cycle. The bench provokes this by offering a read of the same pair in the cycle right after a word write is accepted. It then judges that `req_ready` was held low for exactly that one cycle, and that the delayed read returns the freshly merged doubleword rather than the old one. Random mixes of word and doubleword traffic, with paired mode toggled between operations, are compared against a per-logical-register reference array.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
    parameter int NLOG  = 32;
    parameter int NPHYS = 64;
    parameter int DW    = 64;
    localparam int HW   = DW / 2;
    localparam int LW   = $clog2(NLOG);
    localparam int PW   = $clog2(NPHYS);

    typedef enum logic [1:0] {
        OP_WWR = 2'b00,
        OP_WRD = 2'b01,
        OP_DWR = 2'b10,
        OP_DRD = 2'b11
    } xfer_op_e;

    typedef struct packed {
        logic [LW-1:0] lreg;
        logic          hi;
        logic          paired;
        logic [PW-1:0] tag;
        logic [HW-1:0] word;
    } pend_t;

    function automatic logic [LW-1:0] eff_lreg(input logic [LW-1:0] l, input logic paired);
        return paired ? {l[LW-1:1], 1'b0} : l;
    endfunction

    function automatic logic [DW-1:0] merge_word(input logic [DW-1:0] old,
                                                 input logic [HW-1:0] word,
                                                 input logic hi, input logic paired);
        if (!paired)
            return {{HW{1'b0}}, word};
        else if (hi)
            return {word, old[HW-1:0]};
        else
            return {old[DW-1:HW], word};
    endfunction

    function automatic logic [HW-1:0] pick_half(input logic [DW-1:0] d,
                                                input logic hi, input logic paired);
        return (paired && hi) ? d[DW-1:HW] : d[HW-1:0];
    endfunction
endpackage

// File: rtl/fpwm_map.sv
module fpwm_map
    import fpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] look_lreg,
    output logic [PW-1:0] look_tag,
    input  logic          we,
    input  logic [LW-1:0] waddr,
    input  logic [PW-1:0] wtag
);
    logic [PW-1:0] tbl [NLOG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLOG; i++) tbl[i] <= PW'(i);
        end else if (we) begin
            tbl[waddr] <= wtag;
        end
    end

    assign look_tag = tbl[look_lreg];
endmodule

// File: rtl/fpwm_prf.sv
module fpwm_prf
    import fpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [NPHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    p_wr_addr_known_r6: assert property (@(posedge clk) disable iff (rst)
        we |-> !$isunknown(waddr));
endmodule

// File: rtl/fpwm_ctrl.sv
module fpwm_ctrl
    import fpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  xfer_op_e      op,
    input  logic [LW-1:0] lreg_eff,
    input  logic          hi,
    input  logic          paired,
    input  logic [PW-1:0] tag,
    input  logic [HW-1:0] word,
    output logic          busy,
    output pend_t         pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            pend <= '0;
        end else if (busy) begin
            busy <= 1'b0;
        end else if (accept && op == OP_WWR) begin
            busy        <= 1'b1;
            pend.lreg   <= lreg_eff;
            pend.hi     <= hi;
            pend.paired <= paired;
            pend.tag    <= tag;
            pend.word   <= word;
        end
    end

    p_busy_single_r4: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    p_wwr_sets_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_WWR) |=> busy);
    p_dwr_no_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_DWR) |=> !busy);
endmodule

// File: rtl/fpwm_resp.sv
module fpwm_resp
    import fpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_take,
    input  logic          is_word,
    input  logic          hi,
    input  logic          paired,
    input  logic [DW-1:0] rdata,
    output logic          vld,
    output logic [DW-1:0] data
);
    logic word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= 1'b0;
            data   <= '0;
            word_q <= 1'b0;
        end else begin
            vld    <= rd_take;
            word_q <= rd_take && is_word;
            if (rd_take)
                data <= is_word ? {{HW{1'b0}}, pick_half(rdata, hi, paired)} : rdata;
        end
    end

    p_word_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (vld && word_q) |-> (data[DW-1:HW] == '0));
endmodule

// File: rtl/fp_word_merge.sv
module fp_word_merge
    import fpwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          paired_mode,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [4:0]    req_lreg,
    input  logic [5:0]    req_tag,
    input  logic [63:0]   req_wdata,
    output logic          rd_valid,
    output logic [63:0]   rd_data
);
    xfer_op_e      op;
    logic          accept;
    logic          rd_take;
    logic          busy;
    pend_t         pend;
    logic [LW-1:0] lreg_e;
    logic [LW-1:0] look_l;
    logic [PW-1:0] look_tag;
    logic [DW-1:0] port_data;
    logic          map_we;
    logic [LW-1:0] map_waddr;
    logic [PW-1:0] map_wtag;
    logic          map_w_paired;
    logic          prf_we;
    logic [PW-1:0] prf_waddr;
    logic [DW-1:0] prf_wdata;

    assign op        = xfer_op_e'(req_op);
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign rd_take   = accept && (op == OP_WRD || op == OP_DRD);
    assign lreg_e    = eff_lreg(req_lreg, paired_mode);

    // Shared read port: the pending merge has priority over a new request.
    assign look_l = busy ? pend.lreg : lreg_e;

    always_comb begin
        map_we       = 1'b0;
        map_waddr    = lreg_e;
        map_wtag     = req_tag;
        map_w_paired = paired_mode;
        prf_we       = 1'b0;
        prf_waddr    = req_tag;
        prf_wdata    = req_wdata;
        if (busy) begin
            map_we       = 1'b1;
            map_waddr    = pend.lreg;
            map_wtag     = pend.tag;
            map_w_paired = pend.paired;
            prf_we       = 1'b1;
            prf_waddr    = pend.tag;
            prf_wdata    = merge_word(port_data, pend.word, pend.hi, pend.paired);
        end else if (accept && op == OP_DWR) begin
            map_we = 1'b1;
            prf_we = 1'b1;
        end
    end

    fpwm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .accept(accept), .op(op), .lreg_eff(lreg_e),
        .hi(req_lreg[0]), .paired(paired_mode), .tag(req_tag),
        .word(req_wdata[HW-1:0]), .busy(busy), .pend(pend)
    );

    fpwm_map u_map (
        .clk(clk), .rst(rst), .look_lreg(look_l), .look_tag(look_tag),
        .we(map_we), .waddr(map_waddr), .wtag(map_wtag)
    );

    fpwm_prf u_prf (
        .clk(clk), .rst(rst), .raddr(look_tag), .rdata(port_data),
        .we(prf_we), .waddr(prf_waddr), .wdata(prf_wdata)
    );

    fpwm_resp u_resp (
        .clk(clk), .rst(rst), .rd_take(rd_take), .is_word(op == OP_WRD),
        .hi(req_lreg[0]), .paired(paired_mode), .rdata(port_data),
        .vld(rd_valid), .data(rd_data)
    );

    p_paired_even_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (map_we && map_w_paired) |-> !map_waddr[0]);
    p_read_answers_r7: assert property (@(posedge clk) disable iff (rst)
        rd_take |=> rd_valid);
    p_write_silent_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_take |=> !rd_valid);
    p_merge_keeps_low_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && pend.paired && pend.hi) |-> (prf_wdata[HW-1:0] == port_data[HW-1:0]));
    p_merge_keeps_high_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && pend.paired && !pend.hi) |-> (prf_wdata[DW-1:HW] == port_data[DW-1:HW]));
endmodule

// File: tb/tb_fp_word_merge.sv
`timescale 1ns/1ps
module tb_fp_word_merge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        paired_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [4:0]  req_lreg = '0;
    logic [5:0]  req_tag = '0;
    logic [63:0] req_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] refv [32];
    logic [5:0]  cur_tag [32];

    always #2.5 clk = ~clk;

    fp_word_merge dut (
        .clk(clk), .rst(rst), .paired_mode(paired_mode), .req_valid(req_valid),
        .req_ready(req_ready), .req_op(req_op), .req_lreg(req_lreg), .req_tag(req_tag),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [4:0] eff(input logic [4:0] l);
        return paired_mode ? {l[4:1], 1'b0} : l;
    endfunction

    function automatic logic [5:0] fresh_tag();
        logic [5:0] t = 6'($urandom);
        for (int k = 0; k < 64; k++) begin
            bit used = 1'b0;
            for (int j = 0; j < 32; j++) if (cur_tag[j] == t) used = 1'b1;
            if (!used) return t;
            t = t + 6'd1;
        end
        return t;
    endfunction

    function automatic logic [63:0] exp_read(input logic [1:0] op, input logic [4:0] l);
        logic [63:0] d = refv[eff(l)];
        if (op == 2'b11) return d;
        return {32'h0, (paired_mode && l[0]) ? d[63:32] : d[31:0]};
    endfunction

    // Issues one request; returns the data seen one cycle after acceptance.
    task automatic do_op(input logic [1:0] op, input logic [4:0] l,
                         input logic [63:0] wd, output logic [63:0] got, output bit stalled);
        logic [4:0] e = eff(l);
        logic [5:0] t = 6'd0;
        stalled = 1'b0;
        if (op == 2'b00 || op == 2'b10) begin
            t = fresh_tag();
            cur_tag[e] = t;
        end
        req_op = op; req_lreg = l; req_tag = t; req_wdata = wd; req_valid = 1'b1;
        while (!req_ready) begin
            stalled = 1'b1;
            check("R4 no answer while held", {63'h0, rd_valid}, 64'h0);
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        got = rd_data;
        if (op == 2'b00) begin
            check("R4 ready low after word write", {63'h0, req_ready}, 64'h0);
            check("R7 no rd_valid on write", {63'h0, rd_valid}, 64'h0);
            if (!paired_mode) refv[e] = {32'h0, wd[31:0]};
            else if (l[0]) refv[e][63:32] = wd[31:0];
            else refv[e][31:0] = wd[31:0];
        end else if (op == 2'b10) begin
            check("R6 ready stays high", {63'h0, req_ready}, 64'h1);
            check("R7 no rd_valid on write", {63'h0, rd_valid}, 64'h0);
            refv[e] = wd;
        end else begin
            check(op == 2'b01 ? "R5 rd_valid" : "R7 rd_valid", {63'h0, rd_valid}, 64'h1);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] op, input logic [4:0] l);
        logic [63:0] g;
        logic [63:0] x;
        bit s;
        x = exp_read(op, l);
        do_op(op, l, 64'h0, g, s);
        check(tag, g, x);
    endtask

    task automatic wr(input logic [1:0] op, input logic [4:0] l, input logic [63:0] d);
        logic [63:0] g;
        bit s;
        do_op(op, l, d, g, s);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin refv[i] = '0; cur_tag[i] = 6'(i); end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 ready after reset", {63'h0, req_ready}, 64'h1);
        check("R1 rd_valid after reset", {63'h0, rd_valid}, 64'h0);
        rd_chk("R1 zero register", 2'b11, 5'd5);
        paired_mode = 1'b1;
        rd_chk("R1 zero pair", 2'b11, 5'd9);

        // R2 / R3
        wr(2'b00, 5'd3, 64'h0000_0000_AAAA_1111);
        rd_chk("R2 odd word", 2'b01, 5'd3);
        rd_chk("R2 even half untouched", 2'b01, 5'd2);
        check("R2 pair value", refv[2], 64'hAAAA_1111_0000_0000);
        rd_chk("R3 pair via even", 2'b11, 5'd2);
        rd_chk("R3 pair via odd", 2'b11, 5'd3);
        wr(2'b00, 5'd2, 64'h0000_0000_BBBB_2222);
        rd_chk("R2 high kept after low write", 2'b11, 5'd3);

        // R4: read offered right behind a word write to the same pair
        begin
            logic [63:0] g; logic [63:0] x; bit s;
            wr(2'b00, 5'd11, 64'h0000_0000_C0DE_0011);
            x = exp_read(2'b11, 5'd10);
            do_op(2'b11, 5'd10, 64'h0, g, s);
            check("R4 read was held", {63'h0, s}, 64'h1);
            check("R4 held read sees merge", g, x);
        end

        // R5 / R6 / R7
        wr(2'b10, 5'd13, 64'h1234_5678_9ABC_DEF0);
        rd_chk("R5 high half of double", 2'b01, 5'd13);
        rd_chk("R5 low half of double", 2'b01, 5'd12);
        rd_chk("R7 full double", 2'b11, 5'd12);

        // R8 / R9
        paired_mode = 1'b0;
        wr(2'b10, 5'd7, 64'h7777_0000_7777_0000);
        wr(2'b00, 5'd21, 64'hFFFF_FFFF_0000_DEAD);
        rd_chk("R8 word write clears high", 2'b11, 5'd21);
        rd_chk("R8 word read low half", 2'b01, 5'd7);
        paired_mode = 1'b1;
        wr(2'b00, 5'd7, 64'h0000_0000_5555_5555);
        wr(2'b10, 5'd7, 64'h0101_0101_0202_0202);
        rd_chk("R3 pair 6/7", 2'b11, 5'd7);
        paired_mode = 1'b0;
        rd_chk("R9 odd entry kept", 2'b11, 5'd7);
        check("R9 odd value", refv[7], 64'h7777_0000_7777_0000);

        // random mix
        void'($urandom(32'd77));
        for (int n = 0; n < 800; n++) begin
            logic [1:0] op = 2'($urandom);
            logic [4:0] l = 5'($urandom);
            logic [63:0] d = {$urandom, $urandom};
            if ($urandom % 16 == 0) paired_mode = ~paired_mode;
            if (op == 2'b01 || op == 2'b11)
                rd_chk(paired_mode ? "R2 R3 random read" : "R8 random read", op, l);
            else
                wr(op, l, d);
        end
        for (int i = 0; i < 32; i++) rd_chk("R9 final sweep", 2'b11, 5'(i));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got %0d exp %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule